// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Readout Controller

This block sits on the host side of a synchronous 3- or 4-wire serial link to a delta-sigma converter. On a start request it selects the converter, holds the serial clock low and watches the converter's data line. That line reads high while a conversion is still running and drops low once a result is ready. When it drops, the controller generates 32 clock pulses from a divided system clock. It samples one frame bit on every rising edge, most significant bit first. On the same pulses it sends a configuration word to the converter, which selects the channel, rejection frequency, speed and temperature sensor.

After the last pulse the controller deselects the converter. Reading the whole frame makes the converter start its next conversion. The controller then splits the frame into its fields and holds them on a valid/ready output until the consumer takes them. The fields are the ready flag, the sign, a 24-bit magnitude and 5 sub-LSB bits, plus an error flag when the always-zero bit is set. If the ready indication never arrives within a set number of cycles, the controller deselects the converter and raises a timeout flag.

Top module: `adcrd_ctrl`

## Requirements
- R1: After reset, ser_cs_n is 1, ser_sck is 0, ser_mosi is 0, and busy, res_valid and timeout are all 0.
- R2: A start pulse accepted while idle (and with no result held) drives ser_cs_n low in the next cycle with ser_sck low and busy high, and captures cfg_word.
- R3: While selected and waiting, no ser_sck pulse is produced until ser_miso is sampled low.
- R4: Once ser_miso is seen low, exactly 32 ser_sck pulses are produced with a period of 2*SCK_HALF clock cycles. ser_miso is sampled at each rising edge and the first sample is frame bit 31.
- R5: ser_mosi carries cfg_word MSB first, one bit per ser_sck period, and is stable across each rising edge of ser_sck. After CFG_BITS bits it is 0.
- R6: After the 32nd pulse, ser_sck returns low, ser_cs_n goes high, busy goes low and res_valid goes high.
- R7: Field split: res_status = frame bit 31, res_sign = bit 29, res_mag = bits 28..5, res_sub = bits 4..0.
- R8: res_frame_err is 1 exactly when frame bit 30 was 1.
- R9: While res_valid is 1 and res_ready is 0, res_valid and all result fields stay unchanged and a start pulse is ignored (the link stays deselected). res_valid clears one cycle after res_ready is seen.
- R10: If ser_miso stays high for POLL_LIMIT cycles of waiting, ser_cs_n returns high, timeout becomes 1, no pulse is produced and res_valid stays 0. timeout clears when the next start is accepted.
- R11: busy is 1 exactly while ser_cs_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one readout |
| cfg_word | input | CFG_BITS | Configuration word sent to the converter |
| busy | output | 1 | Readout in progress (waiting or shifting) |
| timeout | output | 1 | Ready indication never arrived |
| res_valid | output | 1 | Result fields are valid |
| res_ready | input | 1 | Consumer accepts the result |
| res_status | output | 1 | Ready flag from the frame |
| res_sign | output | 1 | Sign bit from the frame |
| res_mag | output | 24 | Conversion magnitude |
| res_sub | output | 5 | Sub-LSB bits |
| res_frame_err | output | 1 | Always-zero bit was set |
| ser_cs_n | output | 1 | Converter select, active low |
| ser_sck | output | 1 | Serial clock to the converter |
| ser_mosi | output | 1 | Configuration bits to the converter |
| ser_miso | input | 1 | Ready flag and frame bits from the converter |

## Verification
The hardest situations to reach are the ones where the converter misbehaves or the consumer stalls. In the first, the data line never drops, so the wait has to run for its full limit. In the second, a start request arrives while an earlier result is still held. The bench's converter model can keep its ready indication high forever. The bench counts cycles to the exact expiry edge and then confirms that no clock pulse reached the model. A separate scenario leaves res_ready low after a readout, issues a start, and checks at the pins that the link stays deselected and the held fields do not move.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

    localparam int FRAME_BITS = 32;
    localparam int MAG_BITS   = 24;
    localparam int SUB_BITS   = 5;
    localparam int STAT_POS   = FRAME_BITS - 1;
    localparam int DUMMY_POS  = FRAME_BITS - 2;
    localparam int SIGN_POS   = FRAME_BITS - 3;
    localparam int MAG_LSB    = SUB_BITS;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_POLL  = 2'd1,
        ST_SHIFT = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic                status;
        logic                sign;
        logic [MAG_BITS-1:0] mag;
        logic [SUB_BITS-1:0] sub;
        logic                err;
    } rd_fields_t;

endpackage

// File: rtl/adcrd_sck_gen.sv
module adcrd_sck_gen #(
    parameter int SCK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sck;
    } div_t;

    div_t d, q;
    logic wrap;

    always_comb begin
        d    = q;
        wrap = (q.cnt == CW'(SCK_HALF - 1));
        if (!run) begin
            d.cnt = '0;
            d.sck = 1'b0;
        end else if (wrap) begin
            d.cnt = '0;
            d.sck = ~q.sck;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck      = q.sck;
    assign rise_stb = run & wrap & ~q.sck;
    assign fall_stb = run & wrap &  q.sck;

endmodule

// File: rtl/adcrd_poll_timer.sv
module adcrd_poll_timer #(
    parameter int POLL_LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic expired
);
    localparam int CW = $clog2(POLL_LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        if (!en) d.cnt = '0;
        else     d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign expired = en & (q.cnt == CW'(POLL_LIMIT - 1));

endmodule

// File: rtl/adcrd_frame_split.sv
module adcrd_frame_split
    import adcrd_pkg::*;
(
    input  logic [FRAME_BITS-1:0] frame,
    output rd_fields_t            fields
);
    always_comb begin
        fields.status = frame[STAT_POS];
        fields.sign   = frame[SIGN_POS];
        fields.mag    = frame[SIGN_POS-1:MAG_LSB];
        fields.sub    = frame[SUB_BITS-1:0];
        fields.err    = frame[DUMMY_POS];
    end

endmodule

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
    import adcrd_pkg::*;
#(
    parameter int CFG_BITS   = 16,
    parameter int SCK_HALF   = 2,
    parameter int POLL_LIMIT = 1000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CFG_BITS-1:0] cfg_word,
    output logic                busy,
    output logic                timeout,
    output logic                res_valid,
    input  logic                res_ready,
    output logic                res_status,
    output logic                res_sign,
    output logic [MAG_BITS-1:0] res_mag,
    output logic [SUB_BITS-1:0] res_sub,
    output logic                res_frame_err,
    output logic                ser_cs_n,
    output logic                ser_sck,
    output logic                ser_mosi,
    input  logic                ser_miso
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        rd_state_e             state;
        logic                  cs_n;
        logic [FRAME_BITS-1:0] frame;
        logic [CFG_BITS-1:0]   cfg_sh;
        logic [CNT_W-1:0]      bitcnt;
        logic                  last;
        logic                  valid;
        rd_fields_t            res;
        logic                  tmo;
    } ctl_t;

    ctl_t       d, q;
    logic       run, rise_stb, fall_stb, expired;
    rd_fields_t parsed;

    adcrd_sck_gen #(.SCK_HALF(SCK_HALF)) u_sck (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .sck      (ser_sck),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    adcrd_poll_timer #(.POLL_LIMIT(POLL_LIMIT)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (q.state == ST_POLL),
        .expired (expired)
    );

    adcrd_frame_split u_split (
        .frame  (q.frame),
        .fields (parsed)
    );

    assign run = (q.state == ST_SHIFT);

    always_comb begin
        d = q;
        if (q.valid && res_ready) d.valid = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start && !q.valid) begin
                    d.state  = ST_POLL;
                    d.cs_n   = 1'b0;
                    d.cfg_sh = cfg_word;
                    d.bitcnt = '0;
                    d.last   = 1'b0;
                    d.tmo    = 1'b0;
                end
            end
            ST_POLL: begin
                if (!ser_miso) begin
                    d.state = ST_SHIFT;
                end else if (expired) begin
                    d.state = ST_IDLE;
                    d.cs_n  = 1'b1;
                    d.tmo   = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (rise_stb) begin
                    d.frame  = {q.frame[FRAME_BITS-2:0], ser_miso};
                    d.bitcnt = q.bitcnt + 1'b1;
                    if (q.bitcnt == CNT_W'(FRAME_BITS - 1)) d.last = 1'b1;
                end
                if (fall_stb) begin
                    if (q.last) begin
                        d.state = ST_IDLE;
                        d.cs_n  = 1'b1;
                        d.valid = 1'b1;
                        d.res   = parsed;
                    end else begin
                        d.cfg_sh = {q.cfg_sh[CFG_BITS-2:0], 1'b0};
                    end
                end
            end
            default: begin
                d.state = ST_IDLE;
                d.cs_n  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy          = (q.state != ST_IDLE);
    assign timeout       = q.tmo;
    assign res_valid     = q.valid;
    assign res_status    = q.res.status;
    assign res_sign      = q.res.sign;
    assign res_mag       = q.res.mag;
    assign res_sub       = q.res.sub;
    assign res_frame_err = q.res.err;
    assign ser_cs_n      = q.cs_n;
    assign ser_mosi      = q.cfg_sh[CFG_BITS-1] & ~q.cs_n;

endmodule

// File: rtl/adcrd_ctrl_chk.sv
module adcrd_ctrl_chk
    import adcrd_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                timeout,
    input logic                res_valid,
    input logic                res_ready,
    input logic                res_sign,
    input logic [MAG_BITS-1:0] res_mag,
    input logic [SUB_BITS-1:0] res_sub,
    input logic                ser_cs_n,
    input logic                ser_sck,
    input logic                ser_mosi
);
    AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        ser_cs_n |-> !ser_sck); // R6

    AST_SELECT_WITH_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_cs_n) |-> !ser_sck); // R2

    AST_BUSY_MATCHES_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        busy == !ser_cs_n); // R11

    AST_MOSI_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_sck) |-> $stable(ser_mosi)); // R5

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_mag) && $stable(res_sub) && $stable(res_sign))); // R9

    AST_TIMEOUT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> (ser_cs_n && !res_valid)); // R10

endmodule

bind adcrd_ctrl adcrd_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .timeout   (timeout),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_sign  (res_sign),
    .res_mag   (res_mag),
    .res_sub   (res_sub),
    .ser_cs_n  (ser_cs_n),
    .ser_sck   (ser_sck),
    .ser_mosi  (ser_mosi)
);

// File: tb/sim_adcrd_ctrl.sv
`timescale 1ns/1ps
module sim_adcrd_ctrl;
    localparam int CFG_BITS   = 16;
    localparam int SCK_HALF   = 2;
    localparam int POLL_LIMIT = 1000;
    localparam realtime SCK_PER = 2.0 * SCK_HALF * 5.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] cfg_word = '0;
    logic        res_ready = 1'b0;
    logic        busy, timeout, res_valid, res_status, res_sign, res_frame_err;
    logic [23:0] res_mag;
    logic [4:0]  res_sub;
    logic        ser_cs_n, ser_sck, ser_mosi, ser_miso;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    adcrd_ctrl #(.CFG_BITS(CFG_BITS), .SCK_HALF(SCK_HALF), .POLL_LIMIT(POLL_LIMIT)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_word(cfg_word),
        .busy(busy), .timeout(timeout), .res_valid(res_valid), .res_ready(res_ready),
        .res_status(res_status), .res_sign(res_sign), .res_mag(res_mag), .res_sub(res_sub),
        .res_frame_err(res_frame_err), .ser_cs_n(ser_cs_n), .ser_sck(ser_sck),
        .ser_mosi(ser_mosi), .ser_miso(ser_miso)
    );

    // converter model
    logic        m_ready = 1'b0;
    logic [31:0] m_frame = '0;
    logic [31:0] m_mosi_cap = '0;
    int          m_idx = 31;
    int          m_rises = 0;
    int          m_rises_unready = 0;
    int          m_bad_period = 0;
    int          m_cs_fall_bad = 0;
    realtime     m_last_rise = 0.0;

    assign ser_miso = ser_cs_n ? 1'b1 : (!m_ready ? 1'b1 : m_frame[m_idx]);

    always @(negedge ser_cs_n) begin
        m_idx   = 31;
        m_rises = 0;
        if (ser_sck) m_cs_fall_bad++;
    end

    always @(posedge ser_sck) begin
        if (!m_ready) m_rises_unready++;
        m_rises++;
        m_mosi_cap = {m_mosi_cap[30:0], ser_mosi};
        if (m_rises > 1 && ($realtime - m_last_rise) != SCK_PER) m_bad_period++;
        m_last_rise = $realtime;
    end

    always @(negedge ser_sck) begin
        if (m_idx > 0) m_idx--;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic pulse_start(input logic [15:0] cfg);
        @(negedge clk);
        cfg_word = cfg;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    task automatic wait_valid();
        int n = 0;
        while (!res_valid && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        chk("R1 cs_n", {31'd0, ser_cs_n}, 32'd1);
        chk("R1 sck", {31'd0, ser_sck}, 32'd0);
        chk("R1 mosi", {31'd0, ser_mosi}, 32'd0);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 valid", {31'd0, res_valid}, 32'd0);
        chk("R1 timeout", {31'd0, timeout}, 32'd0);
    endtask

    task automatic t_read(input logic [31:0] frame, input logic [15:0] cfg, input int delay,
                          input bit try_blocked_start);
        logic [23:0] mag_hold;
        int          rises_hold;
        m_frame         = frame;
        m_ready         = 1'b0;
        m_rises_unready = 0;
        m_bad_period    = 0;
        pulse_start(cfg);
        chk("R2 cs_n low", {31'd0, ser_cs_n}, 32'd0);
        chk("R2 sck low", {31'd0, ser_sck}, 32'd0);
        chk("R11 busy", {31'd0, busy}, 32'd1);
        repeat (delay) @(negedge clk);
        m_ready = 1'b1;
        wait_valid();
        chk("R3 no pulses while busy converting", m_rises_unready, 32'd0);
        chk("R4 pulse count", m_rises, 32'd32);
        chk("R4 sck period", m_bad_period, 32'd0);
        chk("R5 mosi bits", m_mosi_cap, {cfg, 16'h0000});
        chk("R6 cs_n high", {31'd0, ser_cs_n}, 32'd1);
        chk("R6 sck low", {31'd0, ser_sck}, 32'd0);
        chk("R6 busy low", {31'd0, busy}, 32'd0);
        chk("R6 valid", {31'd0, res_valid}, 32'd1);
        chk("R7 status", {31'd0, res_status}, {31'd0, frame[31]});
        chk("R7 sign", {31'd0, res_sign}, {31'd0, frame[29]});
        chk("R7 mag", {8'd0, res_mag}, {8'd0, frame[28:5]});
        chk("R7 sub", {27'd0, res_sub}, {27'd0, frame[4:0]});
        chk("R8 frame err", {31'd0, res_frame_err}, {31'd0, frame[30]});
        mag_hold   = res_mag;
        rises_hold = m_rises;
        if (try_blocked_start) begin
            m_ready = 1'b0;
            pulse_start(~cfg);
            repeat (6) begin
                @(negedge clk);
                chk("R9 start ignored cs_n", {31'd0, ser_cs_n}, 32'd1);
            end
            chk("R9 no pulses", m_rises, rises_hold);
            chk("R9 valid held", {31'd0, res_valid}, 32'd1);
            chk("R9 mag held", {8'd0, res_mag}, {8'd0, mag_hold});
        end
        @(negedge clk);
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        chk("R9 valid cleared", {31'd0, res_valid}, 32'd0);
    endtask

    task automatic t_timeout();
        int n = 0;
        m_ready = 1'b0;
        m_rises = 0;
        pulse_start(16'hA5A5);
        while (!timeout && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk("R10 timeout raised", {31'd0, timeout}, 32'd1);
        chk("R10 expiry cycle", n, POLL_LIMIT);
        chk("R10 cs_n released", {31'd0, ser_cs_n}, 32'd1);
        chk("R10 no result", {31'd0, res_valid}, 32'd0);
        chk("R10 no pulses", m_rises, 32'd0);
        chk("R11 busy low", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_read(32'h1ABCDEF3, 16'hC3A1, 0, 1'b0);
        t_read(32'h2F0F0A55, 16'h8001, 7, 1'b1);
        t_read(32'h4000001F, 16'h7FFE, 30, 1'b0);
        t_read(32'h3FFFFFFF, 16'hFFFF, 3, 1'b0);
        t_timeout();
        m_ready = 1'b0;
        pulse_start(16'h1234);
        chk("R10 timeout cleared on start", {31'd0, timeout}, 32'd0);
        m_ready = 1'b1;
        wait_valid();
        chk("R4 pulse count after timeout", m_rises, 32'd32);
        chk("R2 cs fall with sck low", m_cs_fall_bad, 32'd0);
        finish_run();
    end

endmodule